// File: doc/BRIEF.md
# Width-Selectable ALU with Flag Write Mask

This block is the arithmetic and logic unit of an accumulator processor. On each clock edge it takes an operation code, two operands and the current carry, decimal and width settings. One cycle later it presents a result, the new negative, overflow, zero and carry flags, a four-bit mask that says which of those flags the processor should write back, and a strobe that says whether the result should be written to its destination. The width input comes from the accumulator-size or index-size status bit, whichever applies to the instruction. When it selects the narrow width, only the low half of the operands takes part and the high half of the destination passes through unchanged.

Each operation class updates its own subset of flags. Bit test uses a different mask for immediate operands than for memory operands. Compare writes flags only. Byte exchange always works on the full word. Add and subtract have a packed-BCD path, used when the decimal input is high. Operand fetch, addressing and register storage belong to the surrounding datapath.

There is no sequencing state. The only registers are the output registers, loaded on every clock edge after reset.

Top module: `wfalu_core`

## Requirements
- R1: While `rst_n` is low, every output is zero: result, write strobe, the four flags and the flag mask.
- R2: Outputs are registered. Inputs sampled at a rising edge appear on the outputs after that edge, and they stay stable until the next rising edge.
- R3: Op 0 (add) computes A+B+carry. Op 1 (subtract) computes A-B-(1-carry), where carry=1 means no borrow. V is signed overflow at the selected width. The mask `flag_we_o[3:0]` is ordered {N,V,Z,C} and is 1111 for both ops.
- R4: With `dec_i` high, ops 0 and 1 treat the operands as packed BCD and give a BCD result. C is the decimal carry (add) or the decimal no-borrow (subtract) out of the top digit. V is the binary signed overflow of the same operands. N and Z come from the BCD result.
- R5: Op 2 (AND), op 3 (OR), op 4 (XOR), op 9 (A+1) and op 10 (A-1) have mask 1010. Their result does not depend on the carry input.
- R6: Op 5 (shift left), op 6 (shift right), op 7 (rotate left) and op 8 (rotate right) act on A and have mask 1011. C receives the bit shifted out. A rotate fills the vacated bit with the carry input, and a shift fills it with 0.
- R7: Op 11 (compare) forms A-B with no borrow in. It has mask 1011 and C=1 when A>=B unsigned. The write strobe is 0 and the result equals A.
- R8: Op 12 (bit test) sets Z when (A AND B) is zero. With `imm_i` low, N and V take the top bit and the next-to-top bit of B at the selected width, and the mask is 1110. With `imm_i` high the mask is 0010. The write strobe is 0.
- R9: Op 13 (test-and-set) returns B OR A. Op 14 (test-and-reset) returns B AND NOT A. For both, Z comes from (A AND B) and the mask is 0010. In narrow mode the high half of the result is B's high half.
- R10: Op 15 (byte exchange) swaps the two halves of A, whatever the width input says. N and Z come from the new low half only. The mask is 1010.
- R11: With `narrow_i` high, N comes from bit 7 and Z from bits 7:0, and the carry and overflow come from the 8-bit operation. The result's high half is the destination operand's high half (A's, or B's for ops 13 and 14).
- R12: Every flag whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (values in R3 to R10) |
| narrow_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| dec_i | input | 1 | Decimal mode for add and subtract |
| imm_i | input | 1 | Bit-test operand is immediate |
| carry_i | input | 1 | Current carry flag |
| a_i | input | 16 | Accumulator or index register operand |
| b_i | input | 16 | Memory or immediate operand |
| result_o | output | 16 | Registered result |
| wr_res_o | output | 1 | Result should be written |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_we_o | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
The hardest behaviour to reach is the decimal path's digit-carry chain. A correction that ripples through every digit, or a subtract that borrows across several zero digits, only happens with particular BCD operand pairs, and uniform random words are almost never valid BCD. So the stimulus builds operands digit by digit whenever decimal mode is on, and directed cases add 99+01 at the narrow width and a multi-digit borrow at the wide width. Narrow-mode pass-through of the high half is exercised with high halves that differ from the low halves, so a leak between halves changes the result.

// File: rtl/wfalu_pkg.sv
`timescale 1ns/1ps
package wfalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_BIT  = 4'd12,
        OP_TSET = 4'd13,
        OP_TCLR = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flag_set_t;

endpackage

// File: rtl/wfalu_adder.sv
`timescale 1ns/1ps
// Binary and packed-BCD adder/subtractor with a narrow-width tap.
module wfalu_adder #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              dec_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int unsigned HALF_W   = DATA_W / 2;
    localparam int unsigned NIB_CNT  = DATA_W / 4;
    localparam int unsigned HALF_NIB = HALF_W / 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   bin_full;
    logic              half_carry;
    logic [NIB_CNT:0]  dchain;
    logic [DATA_W-1:0] dec_sum;
    logic [DATA_W-1:0] lane;
    logic              sa, sb, sr;

    // Subtraction is addition of the one's complement plus carry-in.
    assign b_eff      = sub_i ? ~b_i : b_i;
    assign bin_full   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
    // Carry into the upper half, recovered from the sum bit.
    assign half_carry = a_i[HALF_W] ^ b_eff[HALF_W] ^ bin_full[HALF_W];

    assign dchain[0] = cin_i;

    generate
        for (genvar g = 0; g < NIB_CNT; g++) begin : g_digit
            logic [4:0] raw;
            logic       adj;
            assign raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_eff[4*g +: 4]}
                       + {4'b0000, dchain[g]};
            // Add: fix up digits above nine; subtract: fix up on borrow.
            assign adj = sub_i ? ~raw[4] : (raw > 5'd9);
            assign dchain[g+1] = sub_i ? raw[4] : adj;
            assign dec_sum[4*g +: 4] = sub_i
                ? (raw[3:0] - {1'b0, adj, adj, 1'b0})
                : (raw[3:0] + {1'b0, adj, adj, 1'b0});
        end
    endgenerate

    always_comb begin
        lane = dec_i ? dec_sum : bin_full[DATA_W-1:0];
        if (narrow_i) begin
            sum_o  = {a_i[DATA_W-1:HALF_W], lane[HALF_W-1:0]};
            cout_o = dec_i ? dchain[HALF_NIB] : half_carry;
            sa     = a_i[HALF_W-1];
            sb     = b_eff[HALF_W-1];
            sr     = bin_full[HALF_W-1];
        end else begin
            sum_o  = lane;
            cout_o = dec_i ? dchain[NIB_CNT] : bin_full[DATA_W];
            sa     = a_i[DATA_W-1];
            sb     = b_eff[DATA_W-1];
            sr     = bin_full[DATA_W-1];
        end
        ovf_o = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/wfalu_unit.sv
`timescale 1ns/1ps
// Logic, shift, rotate, step, bit-modify and byte-exchange datapath.
module wfalu_unit
    import wfalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic              narrow_i,
    input  logic              cin_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] raw;
    logic [HALF_W-1:0] keep_hi;
    logic              fill;

    always_comb begin
        raw     = a_i;
        keep_hi = a_i[DATA_W-1:HALF_W];
        cout_o  = 1'b0;
        fill    = 1'b0;
        unique case (op_i)
            OP_AND:  raw = a_i & b_i;
            OP_OR:   raw = a_i | b_i;
            OP_XOR:  raw = a_i ^ b_i;
            OP_INC:  raw = a_i + 1'b1;
            OP_DEC:  raw = a_i - 1'b1;
            OP_SHL, OP_ROL: begin
                fill   = (op_i == OP_ROL) && cin_i;
                raw    = {a_i[DATA_W-2:0], fill};
                cout_o = narrow_i ? a_i[HALF_W-1] : a_i[DATA_W-1];
            end
            OP_SHR, OP_ROR: begin
                fill   = (op_i == OP_ROR) && cin_i;
                raw    = {1'b0, a_i[DATA_W-1:1]};
                if (narrow_i) raw[HALF_W-1] = fill;
                else          raw[DATA_W-1] = fill;
                cout_o = a_i[0];
            end
            OP_TSET: begin
                raw     = b_i | a_i;
                keep_hi = b_i[DATA_W-1:HALF_W];
            end
            OP_TCLR: begin
                raw     = b_i & ~a_i;
                keep_hi = b_i[DATA_W-1:HALF_W];
            end
            OP_SWAP: raw = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
            default: raw = a_i;
        endcase
        if (narrow_i && (op_i != OP_SWAP)) res_o = {keep_hi, raw[HALF_W-1:0]};
        else                               res_o = raw;
    end

endmodule

// File: rtl/wfalu_select.sv
`timescale 1ns/1ps
// Result selection, flag derivation and per-operation flag mask.
module wfalu_select
    import wfalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic              narrow_i,
    input  logic              imm_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] sum_i,
    input  logic              add_cout_i,
    input  logic              add_ovf_i,
    input  logic [DATA_W-1:0] unit_res_i,
    input  logic              unit_cout_i,
    output logic [DATA_W-1:0] res_o,
    output flag_set_t         flags_o,
    output logic [3:0]        mask_o,
    output logic              wr_o
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] probe;
    flag_set_t         val;

    always_comb begin
        res_o = ((op_i == OP_ADD) || (op_i == OP_SUB)) ? sum_i : unit_res_i;

        if ((op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_CMP))
            probe = sum_i;
        else if ((op_i == OP_BIT) || (op_i == OP_TSET) || (op_i == OP_TCLR))
            probe = a_i & b_i;
        else
            probe = unit_res_i;

        val.n = narrow_i ? probe[HALF_W-1] : probe[DATA_W-1];
        val.z = narrow_i ? (probe[HALF_W-1:0] == '0) : (probe == '0);
        val.v = add_ovf_i;
        val.c = add_cout_i;
        mask_o = 4'b0000;
        wr_o   = 1'b1;

        unique case (op_i)
            OP_ADD, OP_SUB:                  mask_o = 4'b1111;
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                  mask_o = 4'b1010;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                mask_o = 4'b1011;
                val.c  = unit_cout_i;
            end
            OP_CMP: begin
                mask_o = 4'b1011;
                wr_o   = 1'b0;
            end
            OP_BIT: begin
                mask_o = imm_i ? 4'b0010 : 4'b1110;
                wr_o   = 1'b0;
                val.n  = narrow_i ? b_i[HALF_W-1] : b_i[DATA_W-1];
                val.v  = narrow_i ? b_i[HALF_W-2] : b_i[DATA_W-2];
            end
            OP_TSET, OP_TCLR:                mask_o = 4'b0010;
            OP_SWAP: begin
                mask_o = 4'b1010;
                val.n  = unit_res_i[HALF_W-1];
                val.z  = (unit_res_i[HALF_W-1:0] == '0);
            end
            default:                         mask_o = 4'b0000;
        endcase

        flags_o = flag_set_t'(val & mask_o);
    end

endmodule

// File: rtl/wfalu_core.sv
`timescale 1ns/1ps
module wfalu_core
    import wfalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              narrow_i,
    input  logic              dec_i,
    input  logic              imm_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_res_o,
    output logic              flag_n_o,
    output logic              flag_v_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic [3:0]        flag_we_o
);
    alu_op_e           op;
    logic              is_sub, use_dec, add_cin;
    logic [DATA_W-1:0] sum, unit_res, res_d;
    logic              add_cout, add_ovf, unit_cout, wr_d;
    flag_set_t         flags_d, flags_q;
    logic [3:0]        mask_d;

    assign op      = alu_op_e'(op_i);
    assign is_sub  = (op == OP_SUB) || (op == OP_CMP);
    assign use_dec = dec_i && ((op == OP_ADD) || (op == OP_SUB));
    assign add_cin = (op == OP_CMP) ? 1'b1 : carry_i;

    wfalu_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i      (a_i),
        .b_i      (b_i),
        .cin_i    (add_cin),
        .sub_i    (is_sub),
        .dec_i    (use_dec),
        .narrow_i (narrow_i),
        .sum_o    (sum),
        .cout_o   (add_cout),
        .ovf_o    (add_ovf)
    );

    wfalu_unit #(.DATA_W(DATA_W)) u_unit (
        .op_i     (op),
        .narrow_i (narrow_i),
        .cin_i    (carry_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .res_o    (unit_res),
        .cout_o   (unit_cout)
    );

    wfalu_select #(.DATA_W(DATA_W)) u_select (
        .op_i        (op),
        .narrow_i    (narrow_i),
        .imm_i       (imm_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .sum_i       (sum),
        .add_cout_i  (add_cout),
        .add_ovf_i   (add_ovf),
        .unit_res_i  (unit_res),
        .unit_cout_i (unit_cout),
        .res_o       (res_d),
        .flags_o     (flags_d),
        .mask_o      (mask_d),
        .wr_o        (wr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_res_o  <= 1'b0;
            flags_q   <= '0;
            flag_we_o <= 4'b0000;
        end else begin
            result_o  <= res_d;
            wr_res_o  <= wr_d;
            flags_q   <= flags_d;
            flag_we_o <= mask_d;
        end
    end

    assign flag_n_o = flags_q.n;
    assign flag_v_o = flags_q.v;
    assign flag_z_o = flags_q.z;
    assign flag_c_o = flags_q.c;

endmodule

// File: rtl/wfalu_core_chk.sv
`timescale 1ns/1ps
module wfalu_core_chk
    import wfalu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              narrow_i,
    input logic              imm_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_res_o,
    input logic              flag_n_o,
    input logic              flag_v_o,
    input logic              flag_z_o,
    input logic              flag_c_o,
    input logic [3:0]        flag_we_o
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0) && !wr_res_o && (flag_we_o == 4'b0000)
                   && !flag_n_o && !flag_v_o && !flag_z_o && !flag_c_o);

    // R5
    logic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && (($past(op_i) == OP_AND) || ($past(op_i) == OP_OR) ||
                  ($past(op_i) == OP_XOR) || ($past(op_i) == OP_INC) ||
                  ($past(op_i) == OP_DEC))
        |-> (flag_we_o == 4'b1010) && wr_res_o);

    // R7
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) == OP_CMP)
        |-> !wr_res_o && (flag_we_o == 4'b1011) && (result_o == $past(a_i)));

    // R8
    bit_imm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) == OP_BIT) && $past(imm_i)
        |-> (flag_we_o == 4'b0010) && !wr_res_o);

    // R10
    swap_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) == OP_SWAP)
        |-> result_o == {$past(a_i[HALF_W-1:0]), $past(a_i[DATA_W-1:HALF_W])});

    // R11
    narrow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(narrow_i) && ($past(op_i) == OP_XOR)
        |-> result_o[DATA_W-1:HALF_W] == $past(a_i[DATA_W-1:HALF_W]));

    // R12
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (flag_we_o[3] || !flag_n_o) && (flag_we_o[2] || !flag_v_o)
               && (flag_we_o[1] || !flag_z_o) && (flag_we_o[0] || !flag_c_o));

endmodule

bind wfalu_core wfalu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .narrow_i  (narrow_i),
    .imm_i     (imm_i),
    .a_i       (a_i),
    .result_o  (result_o),
    .wr_res_o  (wr_res_o),
    .flag_n_o  (flag_n_o),
    .flag_v_o  (flag_v_o),
    .flag_z_o  (flag_z_o),
    .flag_c_o  (flag_c_o),
    .flag_we_o (flag_we_o)
);

// File: tb/wfalu_core_tb_top.sv
`timescale 1ns/1ps
module wfalu_core_tb_top;
    import wfalu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        narrow_i = 1'b0, dec_i = 1'b0, imm_i = 1'b0, carry_i = 1'b0;
    logic [15:0] a_i = 16'h0, b_i = 16'h0;
    logic [15:0] result_o;
    logic        wr_res_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o;
    logic [3:0]  flag_we_o;

    int checks = 0;
    int errors = 0;
    logic [24:0] last_exp = '0;

    always #10 clk = ~clk;   // 50 MHz

    wfalu_core #(.DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .narrow_i(narrow_i),
        .dec_i(dec_i), .imm_i(imm_i), .carry_i(carry_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .wr_res_o(wr_res_o), .flag_n_o(flag_n_o),
        .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
        .flag_we_o(flag_we_o)
    );

    function automatic logic [24:0] observed();
        return {result_o, wr_res_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, flag_we_o};
    endfunction

    // Expected {result, wr, N, V, Z, C, mask} computed from the requirements.
    function automatic logic [24:0] model(input logic [3:0] op, input logic nar,
            input logic dec, input logic imm, input logic [15:0] a,
            input logic [15:0] b, input logic cin);
        int w   = nar ? 8 : 16;
        int msk = nar ? 32'hFF : 32'hFFFF;
        int top = w - 1;
        int am  = int'(a) & msk;
        int bm  = int'(b) & msk;
        int r = 0, res = 0;
        logic n = 0, v = 0, z = 0, c = 0, wr = 1;
        logic [3:0] we = 4'b0000;
        case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                logic sub = (op != OP_ADD);
                logic ci  = (op == OP_CMP) ? 1'b1 : cin;
                logic dm  = dec && (op != OP_CMP);
                int bb  = sub ? (~bm & msk) : bm;
                int s   = am + bb + int'(ci);
                int bin = s & msk;
                v = (((am >> top) & 1) == ((bb >> top) & 1)) &&
                    (((bin >> top) & 1) != ((am >> top) & 1));
                if (!dm) begin
                    r = bin;
                    c = ((s >> w) & 1) != 0;
                end else begin
                    int cy = sub ? (ci ? 0 : 1) : int'(ci);
                    for (int d = 0; d < w / 4; d++) begin
                        int da = (am >> (4*d)) & 15;
                        int db = (bm >> (4*d)) & 15;
                        int t;
                        if (!sub) begin
                            t = da + db + cy;
                            if (t > 9) begin t = t - 10; cy = 1; end else cy = 0;
                        end else begin
                            t = da - db - cy;
                            if (t < 0) begin t = t + 10; cy = 1; end else cy = 0;
                        end
                        r = r | (t << (4*d));
                    end
                    c = sub ? (cy == 0) : (cy != 0);
                end
                n = ((r >> top) & 1) != 0;
                z = (r == 0);
                if (op == OP_CMP) begin res = int'(a); we = 4'b1011; wr = 0; end
                else begin res = (int'(a) & ~msk) | r; we = 4'b1111; end
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                case (op)
                    OP_AND:  r = am & bm;
                    OP_OR:   r = am | bm;
                    OP_XOR:  r = am ^ bm;
                    OP_INC:  r = (am + 1) & msk;
                    default: r = (am - 1) & msk;
                endcase
                res = (int'(a) & ~msk) | r;
                n = ((r >> top) & 1) != 0; z = (r == 0); we = 4'b1010;
            end
            OP_SHL, OP_ROL: begin
                c = ((am >> top) & 1) != 0;
                r = ((am << 1) & msk) | ((op == OP_ROL && cin) ? 1 : 0);
                res = (int'(a) & ~msk) | r;
                n = ((r >> top) & 1) != 0; z = (r == 0); we = 4'b1011;
            end
            OP_SHR, OP_ROR: begin
                c = (am & 1) != 0;
                r = (am >> 1) | ((op == OP_ROR && cin) ? (1 << top) : 0);
                res = (int'(a) & ~msk) | r;
                n = ((r >> top) & 1) != 0; z = (r == 0); we = 4'b1011;
            end
            OP_BIT: begin
                res = int'(a); wr = 0;
                z = ((am & bm) == 0);
                n = ((bm >> top) & 1) != 0;
                v = ((bm >> (top - 1)) & 1) != 0;
                we = imm ? 4'b0010 : 4'b1110;
            end
            OP_TSET, OP_TCLR: begin
                r = (op == OP_TSET) ? (bm | am) : (bm & ~am & msk);
                res = (int'(b) & ~msk) | r;
                z = ((am & bm) == 0); we = 4'b0010;
            end
            default: begin
                res = ((int'(a) & 'hFF) << 8) | ((int'(a) >> 8) & 'hFF);
                n = ((res >> 7) & 1) != 0; z = ((res & 'hFF) == 0); we = 4'b1010;
            end
        endcase
        n = n & we[3]; v = v & we[2]; z = z & we[1]; c = c & we[0];
        return {res[15:0], wr, n, v, z, c, we};
    endfunction

    task automatic check(input string tag, input logic [24:0] got, input logic [24:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got res=%h wr=%b nvzc=%b we=%b, expected res=%h wr=%b nvzc=%b we=%b",
                     tag, got[24:9], got[8], got[7:4], got[3:0],
                     exp[24:9], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    task automatic run_vec(input string tag, input logic [3:0] op, input logic nar,
            input logic dec, input logic imm, input logic [15:0] a,
            input logic [15:0] b, input logic cin);
        @(negedge clk);
        op_i = op; narrow_i = nar; dec_i = dec; imm_i = imm; a_i = a; b_i = b; carry_i = cin;
        last_exp = model(op, nar, dec, imm, a, b, cin);
        @(negedge clk);
        check(tag, observed(), last_exp);
    endtask

    function automatic logic [15:0] rand_bcd();
        logic [15:0] x = '0;
        for (int d = 0; d < 4; d++) x[4*d +: 4] = 4'($urandom % 10);
        return x;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic dec);
        case (op)
            OP_ADD, OP_SUB:                 return dec ? "R4 decimal" : "R3 binary";
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                 return "R5 logic/step";
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: return "R6 shift";
            OP_CMP:                         return "R7 compare";
            OP_BIT:                         return "R8 bit test";
            OP_TSET, OP_TCLR:               return "R9 test-modify";
            default:                        return "R10 swap";
        endcase
    endfunction

    initial begin
        #4000000;
        errors++;
        $display("FAIL R2 watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_word;
        seed_word = $urandom(32'd5150);

        // R1: reset state
        @(negedge clk);
        a_i = 16'hFFFF; b_i = 16'hFFFF; op_i = OP_ADD;
        @(negedge clk);
        check("R1 reset", observed(), 25'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 directed
        run_vec("R3 8-bit overflow", OP_ADD, 1, 0, 0, 16'hAB7F, 16'h0001, 0);
        run_vec("R3 16-bit borrow", OP_SUB, 0, 0, 0, 16'h0000, 16'h0001, 1);
        // R4 directed
        run_vec("R4 narrow 99+01", OP_ADD, 1, 1, 0, 16'h3499, 16'h0001, 0);
        run_vec("R4 wide 1234-0235", OP_SUB, 0, 1, 0, 16'h1234, 16'h0235, 1);
        run_vec("R4 wide 9999+0001", OP_ADD, 0, 1, 0, 16'h9999, 16'h0001, 0);
        // R5 carry ignored
        run_vec("R5 and c=1", OP_AND, 0, 0, 0, 16'h8F0F, 16'hF0F0, 1);
        // R6 rotate narrow
        run_vec("R6 R11 ror narrow", OP_ROR, 1, 0, 0, 16'h1201, 16'h0000, 1);
        // R7 compare equal
        run_vec("R7 cmp equal", OP_CMP, 0, 1, 0, 16'h4242, 16'h4242, 0);
        // R8 bit immediate and memory
        run_vec("R8 bit imm", OP_BIT, 0, 0, 1, 16'h0001, 16'hC000, 0);
        run_vec("R8 bit mem narrow", OP_BIT, 1, 0, 0, 16'h0001, 16'h00C0, 0);
        // R9 test-modify narrow
        run_vec("R9 R11 tclr narrow", OP_TCLR, 1, 0, 0, 16'h55F0, 16'hAAFF, 0);
        // R10 swap
        run_vec("R10 swap", OP_SWAP, 1, 0, 0, 16'h00FF, 16'h0000, 0);
        // R12 masked flags
        run_vec("R12 masked", OP_TSET, 0, 0, 0, 16'h8000, 16'h0000, 1);
        // R11 narrow inc wrap
        run_vec("R11 inc wrap", OP_INC, 1, 0, 0, 16'h12FF, 16'h0000, 0);

        // R2: output holds until the edge, then updates
        @(negedge clk);
        op_i = OP_SWAP; narrow_i = 0; a_i = 16'h1234;
        #5;
        check("R2 hold before edge", observed(), last_exp);
        last_exp = model(OP_SWAP, 0, dec_i, imm_i, 16'h1234, b_i, carry_i);
        @(negedge clk);
        check("R2 after edge", observed(), last_exp);

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            logic [3:0]  op  = 4'($urandom % 16);
            logic        nar = 1'($urandom % 2);
            logic        dec = ($urandom % 3) == 0;
            logic        imm = 1'($urandom % 2);
            logic        cin = 1'($urandom % 2);
            logic [15:0] a   = dec ? rand_bcd() : 16'($urandom);
            logic [15:0] b   = dec ? rand_bcd() : 16'($urandom);
            run_vec(tag_of(op, dec), op, nar, dec, imm, a, b, cin);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule